// File: doc/BRIEF.md
# SMBus Block Transfer Data Buffer

This block sits between a host register interface and an SMBus byte engine while a block read or block write command runs. It stores the command's data bytes in a 32-entry buffer, or in a single byte when the buffered mode bit is clear. Before a write the host loads the buffer and the engine then drains it. During a read the engine fills the buffer and the host empties it. The block counts down the programmed byte total and raises a level interrupt when a chunk is complete. A chunk is 32 bytes in buffered mode and 1 byte in single-byte mode. The interrupt also fires when the whole count is done.

While the interrupt is pending the engine side is stalled. The host clears the interrupt by pulsing `irq_clr`. This resets both buffer indexes to 0 and lets the next chunk proceed. A command with a zero count is refused and sets the error flag. A block write with I2C mode on and either PEC or automatic-acknowledge control on is also refused and sets the error flag.

Top module: `smb_blkbuf`

## Requirements
- R1: With `cfg_buffered`=1 at `cmd_start`, the engine moves up to 32 bytes per chunk. `irq` rises the cycle after the 32nd handshake of a chunk and `busy` stays 1 if bytes remain.
- R2: With `cfg_buffered`=0 at `cmd_start`, only buffer entry 0 is used and `irq` rises the cycle after every engine handshake.
- R3: For a write (`cmd_write`=1), the host loads bytes with `host_wr` from index 0. The engine receives them on `tx_data` in load order. Host accesses while `busy`=1 and `irq`=0 are ignored.
- R4: For a read (`cmd_write`=0), bytes accepted from `rx_data` are stored in arrival order. After `irq`, `host_rd` returns them from index 0.
- R5: `irq` rises and `busy` falls the cycle after the handshake that completes the programmed `cmd_count`, even when the chunk is not full.
- R6: `irq` is a level that stays 1 until a cycle with `irq_clr`=1. Clearing it resets the engine and host indexes to 0 and resumes the transfer.
- R7: `tx_valid` and `rx_ready` are 0 whenever `busy`=0 or `irq`=1.
- R8: A `cmd_start` with `cmd_write`=1, `cfg_i2c`=1 and (`cfg_pec`=1 or `cfg_ackctl`=1) does not start and sets `err`. The same bits on a read start normally.
- R9: A `cmd_start` with `cmd_count`=0 does not start and sets `err`.
- R10: `cmd_start` is ignored while `busy`=1 or `irq`=1. `irq_clr` clears `err`.
- R11: After reset, `irq`, `err`, `busy`, `tx_valid` and `rx_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_buffered | input | 1 | 1 = 32-byte buffer, 0 = single byte |
| cfg_i2c | input | 1 | I2C mode enable |
| cfg_pec | input | 1 | PEC enable |
| cfg_ackctl | input | 1 | Automatic acknowledge control |
| cmd_start | input | 1 | Start command pulse |
| cmd_write | input | 1 | 1 = block write, 0 = block read |
| cmd_count | input | CNT_W | Total byte count |
| irq_clr | input | 1 | Write-1 clear of interrupt and error |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | DW | Host write byte |
| host_rd | input | 1 | Host byte read strobe (advances index) |
| host_rdata | output | DW | Byte at the host index |
| irq | output | 1 | Interrupt level |
| err | output | 1 | Refused-command flag |
| busy | output | 1 | Command in progress |
| tx_valid | output | 1 | Byte available to engine |
| tx_data | output | DW | Byte to engine |
| tx_ready | input | 1 | Engine accepts byte |
| rx_valid | input | 1 | Engine offers byte |
| rx_data | input | DW | Byte from engine |
| rx_ready | output | 1 | Block accepts byte |

## Verification
The assertions check on every cycle the rules that need no data:
- the interrupt holds until cleared and drops after a clear;
- the engine handshakes stay quiet while idle or while the interrupt is pending;
- single-byte mode interrupts after each handshake;
- a zero count is refused;
- a clear removes the error flag.

Only the bench scenarios can show the data side and the sequencing. These cover the order of bytes through the buffer in both directions, chunk boundaries in a 40-byte write, early completion of a short read, and refusal of the invalid write configuration while the same bits on a read are accepted. They also show that starts and host writes arriving mid-transfer are ignored.

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_buffered,
  input  logic             cfg_i2c,
  input  logic             cfg_pec,
  input  logic             cfg_ackctl,
  input  logic             cmd_start,
  input  logic             cmd_write,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             irq_clr,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  output logic             irq,
  output logic             err,
  output logic             busy,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  output logic             rx_ready
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    eptr, hptr;
  logic [CNT_W-1:0] rem;
  logic             busy_q, irq_q, err_q, wr_q, bm_q;

  wire          bm        = busy_q ? bm_q : cfg_buffered;
  wire [PW-1:0] hidx      = bm ? hptr : '0;
  wire [PW-1:0] eidx      = bm_q ? eptr : '0;
  wire          host_ok   = !busy_q || irq_q;
  wire          hwr       = host_wr && host_ok;
  wire          hrd       = host_rd && host_ok;
  wire          bad_cfg   = cmd_write && cfg_i2c && (cfg_pec || cfg_ackctl);
  wire          can_start = cmd_start && !busy_q && !irq_q;
  wire          start_ok  = can_start && (cmd_count != '0) && !bad_cfg;
  wire          start_bad = can_start && !start_ok;
  wire          xfer      = busy_q && !irq_q && (wr_q ? tx_ready : rx_valid);
  wire          last      = rem == CNT_W'(1);
  wire          chunk_end = !bm_q || (eptr == PW'(DEPTH-1));

  assign host_rdata = mem[hidx];
  assign tx_data    = mem[eidx];
  assign tx_valid   = busy_q && wr_q && !irq_q;
  assign rx_ready   = busy_q && !wr_q && !irq_q;
  assign irq        = irq_q;
  assign err        = err_q;
  assign busy       = busy_q;

  always_ff @(posedge clk) begin
    if (hwr) mem[hidx] <= host_wdata;
    else if (xfer && !wr_q) mem[eidx] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      bm_q   <= 1'b0;
      rem    <= '0;
      eptr   <= '0;
      hptr   <= '0;
    end else begin
      if (xfer) begin
        rem  <= rem - CNT_W'(1);
        eptr <= eptr + PW'(1);
        if (last || chunk_end) begin
          irq_q <= 1'b1;
          hptr  <= '0;
          if (last) busy_q <= 1'b0;
        end
      end else if (hwr || hrd) begin
        hptr <= hptr + PW'(1);
      end
      if (irq_clr) begin
        err_q <= 1'b0;
        if (irq_q) begin
          irq_q <= 1'b0;
          eptr  <= '0;
          hptr  <= '0;
        end
      end
      if (start_ok) begin
        busy_q <= 1'b1;
        wr_q   <= cmd_write;
        bm_q   <= cfg_buffered;
        rem    <= cmd_count;
        eptr   <= '0;
        hptr   <= '0;
      end
      if (start_bad) err_q <= 1'b1;
    end
  end
endmodule

module smb_blkbuf_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             irq_clr,
  input logic             err,
  input logic             busy,
  input logic             bm_q,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             cmd_start,
  input logic [CNT_W-1:0] cmd_count
);
  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  a_r6_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq && irq_clr |=> !irq);
  a_r7_stall_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !tx_valid && !rx_ready);
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !rx_ready);
  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && !busy && !irq && cmd_count == '0 |=> err && !busy);
  a_r2_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bm_q && ((tx_valid && tx_ready) || (rx_valid && rx_ready)) |=> irq);
  a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !cmd_start |=> !err);
endmodule

bind smb_blkbuf smb_blkbuf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_clr(irq_clr), .err(err),
  .busy(busy), .bm_q(bm_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .cmd_start(cmd_start),
  .cmd_count(cmd_count)
);

// File: tb/tb_smb_blkbuf.sv
`timescale 1ns/1ps
module tb_smb_blkbuf;
  localparam int DEPTH = 32;
  logic clk = 0, rst_n = 0;
  logic cfg_buffered = 0, cfg_i2c = 0, cfg_pec = 0, cfg_ackctl = 0;
  logic cmd_start = 0, cmd_write = 0, irq_clr = 0, host_wr = 0, host_rd = 0;
  logic [7:0] cmd_count = 0, host_wdata = 0, rx_data = 0;
  logic tx_ready = 0, rx_valid = 0;
  logic [7:0] host_rdata, tx_data;
  logic irq, err, busy, tx_valid, rx_ready;

  smb_blkbuf dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit live = 0, done = 0;

  bit m_busy, m_irq, m_err, m_wr, m_bm;
  int m_rem, m_ep, m_hp;
  bit m_rxhs;
  int rx_taken = 0;
  logic [7:0] rx_q[$], got_tx[$], exp_tx[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // reference model
  always @(posedge clk) begin
    bit p_busy, p_irq, hs, hok, bad;
    if (!rst_n) begin
      m_busy = 0; m_irq = 0; m_err = 0; m_wr = 0; m_bm = 0;
      m_rem = 0; m_ep = 0; m_hp = 0; m_rxhs = 0;
    end else begin
      p_busy = m_busy; p_irq = m_irq;
      hok = !p_busy || p_irq;
      bad = cmd_write && cfg_i2c && (cfg_pec || cfg_ackctl);
      hs = p_busy && !p_irq && (m_wr ? tx_ready : rx_valid);
      if (hs) begin
        if (m_wr) got_tx.push_back(tx_data);
        else m_rxhs = 1;
        m_rem--;
        m_ep = (m_ep + 1) % DEPTH;
        if (m_rem == 0 || !m_bm || m_ep == 0) begin
          m_irq = 1; m_hp = 0;
          if (m_rem == 0) m_busy = 0;
        end
      end else if (hok && (host_wr || host_rd)) m_hp = (m_hp + 1) % DEPTH;
      if (irq_clr) begin
        m_err = 0;
        if (p_irq) begin m_irq = 0; m_ep = 0; m_hp = 0; end
      end
      if (cmd_start && !p_busy && !p_irq) begin
        if (cmd_count == 0 || bad) m_err = 1;
        else begin
          m_busy = 1; m_wr = cmd_write; m_bm = cfg_buffered;
          m_rem = cmd_count; m_ep = 0; m_hp = 0;
        end
      end
    end
  end

  // per-cycle compare, then engine drive
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 0);
      finish_run();
    end
    if (live) begin
      chk(irq === m_irq, "R6 irq", irq, m_irq);
      chk(busy === m_busy, "R5 busy", busy, m_busy);
      chk(err === m_err, "R8 err", err, m_err);
      chk(tx_valid === (m_busy && m_wr && !m_irq), "R7 tx_valid", tx_valid, m_busy && m_wr && !m_irq);
      chk(rx_ready === (m_busy && !m_wr && !m_irq), "R7 rx_ready", rx_ready, m_busy && !m_wr && !m_irq);
    end
    if (m_rxhs) begin
      m_rxhs = 0;
      void'(rx_q.pop_front());
      rx_taken++;
    end
    rx_valid = rx_q.size() > 0;
    rx_data = rx_q.size() > 0 ? rx_q[0] : 8'h00;
    tx_ready = (cyc % 3) != 2;
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic hwrite(logic [7:0] b);
    tick(); host_wr = 1; host_wdata = b;
    tick(); host_wr = 0;
  endtask

  task automatic hread(logic [7:0] exp, string req);
    tick(); chk(host_rdata === exp, req, host_rdata, exp); host_rd = 1;
    tick(); host_rd = 0;
  endtask

  task automatic start(bit wr, int n);
    tick(); cmd_start = 1; cmd_write = wr; cmd_count = 8'(n);
    tick(); cmd_start = 0;
  endtask

  task automatic clr();
    tick(); irq_clr = 1;
    tick(); irq_clr = 0;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 1000 && !irq; k++) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    live = 1;
    chk(!irq && !err && !busy && !tx_valid && !rx_ready, "R11 reset", {irq, err, busy, tx_valid, rx_ready}, 0);

    // buffered write of 40 bytes
    cfg_buffered = 1;
    for (int i = 0; i < 32; i++) begin
      hwrite(8'(i * 7 + 3)); exp_tx.push_back(8'(i * 7 + 3));
    end
    start(1, 40);
    wait_irq();
    chk(got_tx.size() == 32, "R1 chunk size", got_tx.size(), 32);
    chk(busy === 1, "R1 busy after chunk", busy, 1);
    for (int i = 0; i < 8; i++) begin
      hwrite(8'(200 + i)); exp_tx.push_back(8'(200 + i));
    end
    repeat (5) tick();
    chk(irq === 1, "R6 irq held", irq, 1);
    clr();
    wait_irq();
    chk(busy === 0, "R5 busy low at end", busy, 1'b0);
    chk(got_tx.size() == 40, "R5 total bytes", got_tx.size(), 40);
    for (int i = 0; i < 40 && i < got_tx.size(); i++)
      chk(got_tx[i] === exp_tx[i], "R3 tx order", got_tx[i], exp_tx[i]);
    clr();
    chk(irq === 0, "R6 cleared", irq, 0);

    // buffered read of 5 bytes
    for (int i = 0; i < 5; i++) rx_q.push_back(8'(8'h51 + i * 3));
    start(0, 5);
    wait_irq();
    chk(busy === 0, "R5 short read done", busy, 0);
    for (int i = 0; i < 5; i++) hread(8'(8'h51 + i * 3), "R4 readback");
    clr();

    // single-byte read of 3
    cfg_buffered = 0;
    rx_taken = 0;
    for (int i = 0; i < 3; i++) rx_q.push_back(8'(8'hA0 + i));
    start(0, 3);
    for (int k = 1; k <= 3; k++) begin
      wait_irq();
      chk(rx_taken == k, "R2 one byte per irq", rx_taken, k);
      hread(8'(8'hA0 + k - 1), "R2 single readback");
      clr();
    end

    // single-byte write of 2
    got_tx.delete();
    hwrite(8'h3C);
    start(1, 2);
    wait_irq();
    chk(got_tx.size() == 1, "R2 single write chunk", got_tx.size(), 1);
    hwrite(8'hC3);
    clr();
    wait_irq();
    chk(got_tx.size() == 2 && got_tx[0] == 8'h3C && got_tx[1] == 8'hC3, "R3 single write data", got_tx.size(), 2);
    clr();

    // zero count
    cfg_buffered = 1;
    start(1, 0);
    chk(err === 1 && busy === 0, "R9 zero count refused", {err, busy}, 2'b10);
    clr();
    chk(err === 0, "R10 err cleared", err, 0);

    // invalid configurations
    cfg_i2c = 1; cfg_pec = 1;
    start(1, 3);
    chk(err === 1 && busy === 0, "R8 pec write refused", {err, busy}, 2'b10);
    clr();
    cfg_pec = 0; cfg_ackctl = 1;
    start(1, 3);
    chk(err === 1 && busy === 0, "R8 ackctl write refused", {err, busy}, 2'b10);
    clr();
    cfg_pec = 1;
    start(0, 1);
    chk(busy === 1 && err === 0, "R8 read allowed", {busy, err}, 2'b10);
    rx_q.push_back(8'h77);
    wait_irq();
    clr();
    cfg_i2c = 0; cfg_pec = 0; cfg_ackctl = 0;

    // start and host write ignored while running
    start(0, 2);
    start(1, 9);
    chk(busy === 1 && rx_ready === 1, "R10 start ignored while busy", {busy, rx_ready}, 2'b11);
    hwrite(8'hEE);
    rx_q.push_back(8'h12); rx_q.push_back(8'h34);
    wait_irq();
    hread(8'h12, "R3 host write ignored while running");
    hread(8'h34, "R4 second byte");
    clr();
    repeat (4) tick();
    finish_run();
  end
endmodule